// File: doc/BRIEF.md
# Dual-Bank Data Address Generator

This unit supplies data-memory addresses for two memory banks at once. It works beside the arithmetic datapath, so operand addressing takes no instruction cycles. It holds eight pointer registers. Each pointer has its own step register and its own mode register. Pointers 0 to 3 serve the X bank and pointers 4 to 7 serve the Y bank. Because of this split, an X request and a Y request in the same cycle can never reach the same register.

A request selects one pointer of its bank and an operation. The address output shows the selected pointer's current value in that same cycle, with no register on the path. At the next clock edge the pointer moves. The pointer's mode register sets how it moves: plain binary arithmetic, wrap-around inside a circular buffer, or reverse-carry stepping for FFT data reordering. Software-side loading goes through one write port. That port reaches any pointer, step or mode register, and the new value is used from the next cycle.

Top module: `agu_top`

## Requirements
- R1: After reset every pointer reads 0, every step register reads 0 and every mode register reads 16'hFFFF (linear).
- R2: A write with wr_en=1 stores wr_data into the register chosen by wr_kind (0 pointer, 1 step, 2 mode; code 3 stores nothing). wr_reg[2]=0 selects X pointer wr_reg[1:0], and wr_reg[2]=1 selects Y pointer wr_reg[1:0]. A request sees the written value from the following cycle on.
- R3: x_addr and y_addr equal the current value of the selected pointer in the same cycle as the request. Any update appears from the next cycle on (post-modify).
- R4: The operation codes are 0 hold, 1 add one, 2 subtract one, and 3 add the step register. The step value is signed two's complement, except in reverse-carry mode. A cycle with no request, or with operation 0, leaves the pointer unchanged.
- R5: Mode 16'hFFFF gives plain 16-bit arithmetic that wraps modulo 2^16 (FFFF+1=0, 0-1=FFFF).
- R6: A mode value m other than 0 and FFFF gives a circular buffer of size m+1. Let k be the mask of all ones up to the highest set bit of m. The bits above k are kept. The offset (pointer & k) plus the step, if it exceeds m, has m+1 subtracted once.
- R7: In a circular buffer, an offset plus step below zero has m+1 added once, so subtracting one from the buffer base gives base+m.
- R8: Mode 0 is reverse-carry: the next pointer is rev(rev(p)+rev(s)), where rev mirrors the 16 bits and s is 1 or the step register. Subtract-one gives rev(rev(p)-rev(1)).
- R9: X and Y requests in the same cycle are served independently, each with its own operation.
- R10: If a pointer is written and updated in the same cycle, the written value wins.
- R11: A write to one bank leaves every pointer of the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind: 0 pointer, 1 step, 2 mode |
| wr_reg | input | 3 | Register number; bit 2 picks the bank |
| wr_data | input | 16 | Value to write |
| x_req | input | 1 | X bank request |
| x_reg | input | 2 | X pointer select |
| x_op | input | 2 | X operation code |
| x_addr | output | 16 | X bank address |
| y_req | input | 1 | Y bank request |
| y_reg | input | 2 | Y pointer select |
| y_op | input | 2 | Y operation code |
| y_addr | output | 16 | Y bank address |

## Verification
The hardest state to reach from the ports is a circular-buffer pointer sitting exactly at its top or base offset while a step of the right sign is applied. The stimulus gets there with directed sequences: they load a non-power-of-two buffer size and then walk the pointer across both edges. Reverse-carry order comes from a directed 16-point sweep. The random phase loads arbitrary mode and step values into both banks and issues concurrent requests, including writes that collide with updates. Every address is compared with a bench model, in the same cycle, against the requirement formulas.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2,
        OP_ADDN = 2'd3
    } agu_op_e;

    typedef enum logic [1:0] {
        KIND_PTR  = 2'd0,
        KIND_STEP = 2'd1,
        KIND_MODE = 2'd2,
        KIND_NONE = 2'd3
    } agu_kind_e;
endpackage

// File: rtl/agu_step_calc.sv
module agu_step_calc
    import agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur_i,
    input  logic [AW-1:0] step_i,
    input  logic [AW-1:0] mode_i,
    input  agu_op_e       op_i,
    output logic [AW-1:0] nxt_o
);
    localparam int            SW     = AW + 2;
    localparam int            LG     = $clog2(AW);
    localparam logic [AW-1:0] LINEAR = '1;
    localparam logic [AW-1:0] ONE    = AW'(1);

    function automatic logic [AW-1:0] mirror(input logic [AW-1:0] v);
        logic [AW-1:0] o;
        for (int i = 0; i < AW; i++) o[i] = v[AW-1-i];
        return o;
    endfunction

    logic [AW-1:0]        mask;
    logic signed [SW-1:0] delta;
    logic signed [SW-1:0] offs;
    logic signed [SW-1:0] top;
    logic signed [SW-1:0] sum;
    logic [AW-1:0]        rev_sum;

    // mask covering every bit up to the highest set bit of the mode value
    always_comb begin
        mask = mode_i;
        for (int i = 0; i < LG; i++) mask = mask | (mask >> (1 << i));
    end

    always_comb begin
        case (op_i)
            OP_INC:  delta = SW'(1);
            OP_DEC:  delta = -SW'(1);
            OP_ADDN: delta = signed'({{2{step_i[AW-1]}}, step_i});
            default: delta = '0;
        endcase
    end

    always_comb begin
        offs = signed'({2'b00, cur_i & mask});
        top  = signed'({2'b00, mode_i});
        sum  = offs + delta;
        if (delta >= 0 && sum > top) begin
            sum = sum - (top + SW'(1));
        end else if (sum < 0) begin
            sum = sum + (top + SW'(1));
        end
    end

    always_comb begin
        case (op_i)
            OP_INC:  rev_sum = mirror(cur_i) + mirror(ONE);
            OP_DEC:  rev_sum = mirror(cur_i) - mirror(ONE);
            OP_ADDN: rev_sum = mirror(cur_i) + mirror(step_i);
            default: rev_sum = mirror(cur_i);
        endcase
    end

    always_comb begin
        if (op_i == OP_HOLD) begin
            nxt_o = cur_i;
        end else if (mode_i == LINEAR) begin
            nxt_o = cur_i + delta[AW-1:0];
        end else if (mode_i == '0) begin
            nxt_o = mirror(rev_sum);
        end else begin
            nxt_o = (cur_i & ~mask) | (sum[AW-1:0] & mask);
        end
    end
endmodule

// File: rtl/agu_bank.sv
module agu_bank
    import agu_pkg::*;
#(
    parameter  int AW   = 16,
    parameter  int NREG = 4,
    localparam int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  agu_kind_e     wr_kind_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic [AW-1:0] wr_data_i,
    input  logic          rq_en_i,
    input  logic [IW-1:0] rq_idx_i,
    input  agu_op_e       rq_op_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] mode_o
);
    typedef struct packed {
        logic [NREG-1:0][AW-1:0] ptr;
        logic [NREG-1:0][AW-1:0] step;
        logic [NREG-1:0][AW-1:0] mode;
    } bank_state_t;

    bank_state_t   st_d, st_q;
    logic [AW-1:0] nxt_ptr;

    agu_step_calc #(.AW(AW)) u_calc (
        .cur_i  (st_q.ptr[rq_idx_i]),
        .step_i (st_q.step[rq_idx_i]),
        .mode_i (st_q.mode[rq_idx_i]),
        .op_i   (rq_op_i),
        .nxt_o  (nxt_ptr)
    );

    always_comb begin
        st_d = st_q;
        if (rq_en_i && rq_op_i != OP_HOLD) begin
            st_d.ptr[rq_idx_i] = nxt_ptr;
        end
        // the write is applied last so it overrides a same-cycle update
        if (wr_en_i) begin
            case (wr_kind_i)
                KIND_PTR:  st_d.ptr[wr_idx_i]  = wr_data_i;
                KIND_STEP: st_d.step[wr_idx_i] = wr_data_i;
                KIND_MODE: st_d.mode[wr_idx_i] = wr_data_i;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ptr  <= '0;
            st_q.step <= '0;
            st_q.mode <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.ptr[rq_idx_i];
    assign mode_o = st_q.mode[rq_idx_i];
endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter  int AW   = 16,
    parameter  int NREG = 4,
    localparam int IW   = $clog2(NREG),
    localparam int NB   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_kind,
    input  logic [IW:0]   wr_reg,
    input  logic [AW-1:0] wr_data,
    input  logic          x_req,
    input  logic [IW-1:0] x_reg,
    input  logic [1:0]    x_op,
    output logic [AW-1:0] x_addr,
    input  logic          y_req,
    input  logic [IW-1:0] y_reg,
    input  logic [1:0]    y_op,
    output logic [AW-1:0] y_addr
);
    logic          rq_en   [NB];
    logic [IW-1:0] rq_idx  [NB];
    agu_op_e       rq_op   [NB];
    logic [AW-1:0] bank_addr [NB];
    logic [AW-1:0] bank_mode [NB];

    always_comb begin
        rq_en[0]  = x_req;
        rq_idx[0] = x_reg;
        rq_op[0]  = agu_op_e'(x_op);
        rq_en[1]  = y_req;
        rq_idx[1] = y_reg;
        rq_op[1]  = agu_op_e'(y_op);
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        agu_bank #(.AW(AW), .NREG(NREG)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (wr_en && (wr_reg[IW] == 1'(b))),
            .wr_kind_i (agu_kind_e'(wr_kind)),
            .wr_idx_i  (wr_reg[IW-1:0]),
            .wr_data_i (wr_data),
            .rq_en_i   (rq_en[b]),
            .rq_idx_i  (rq_idx[b]),
            .rq_op_i   (rq_op[b]),
            .addr_o    (bank_addr[b]),
            .mode_o    (bank_mode[b])
        );
    end

    assign x_addr = bank_addr[0];
    assign y_addr = bank_addr[1];
endmodule

// File: rtl/agu_top_chk.sv
module agu_top_chk #(
    parameter int AW = 16,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_kind,
    input logic [IW:0]   wr_reg,
    input logic [AW-1:0] wr_data,
    input logic          x_req,
    input logic [IW-1:0] x_reg,
    input logic [1:0]    x_op,
    input logic [AW-1:0] x_addr,
    input logic          y_req,
    input logic [IW-1:0] y_reg,
    input logic [1:0]    y_op,
    input logic [AW-1:0] y_addr,
    input logic [AW-1:0] x_mode,
    input logic [AW-1:0] y_mode
);
    localparam int LG = $clog2(AW);

    function automatic logic [AW-1:0] fill(input logic [AW-1:0] v);
        logic [AW-1:0] o;
        o = v;
        for (int i = 0; i < LG; i++) o = o | (o >> (1 << i));
        return o;
    endfunction

    // R2: a pointer write shows up at the X output the next cycle
    a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en && wr_kind == 2'd0 && !wr_reg[IW]) && x_reg == $past(wr_reg[IW-1:0]))
        |-> x_addr == $past(wr_data));

    // R4: no movement without a moving request or a write
    a_r4_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!wr_en && !(x_req && x_op != 2'd0)) && x_reg == $past(x_reg))
        |-> x_addr == $past(x_addr));

    // R5: linear add-one
    a_r5_linear_inc: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!wr_en && x_req && x_op == 2'd1 && x_mode == '1) && x_reg == $past(x_reg))
        |-> x_addr == $past(x_addr) + AW'(1));

    // R6: circular buffer keeps the bits above its mask
    a_r6_modulo_base: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!wr_en && y_req && y_op != 2'd0 && y_mode != '0 && y_mode != '1)
         && y_reg == $past(y_reg))
        |-> (y_addr & ~fill($past(y_mode))) == ($past(y_addr) & ~fill($past(y_mode))));

    // R11: a Y-bank write leaves a held X pointer alone
    a_r11_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en && wr_reg[IW] && !(x_req && x_op != 2'd0)) && x_reg == $past(x_reg))
        |-> x_addr == $past(x_addr));
endmodule

bind agu_top agu_top_chk #(.AW(AW), .IW(IW)) u_agu_top_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_kind (wr_kind),
    .wr_reg  (wr_reg),
    .wr_data (wr_data),
    .x_req   (x_req),
    .x_reg   (x_reg),
    .x_op    (x_op),
    .x_addr  (x_addr),
    .y_req   (y_req),
    .y_reg   (y_reg),
    .y_op    (y_op),
    .y_addr  (y_addr),
    .x_mode  (bank_mode[0]),
    .y_mode  (bank_mode[1])
);

// File: tb/agu_top_bench.sv
module agu_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = '0;
    logic [2:0]  wr_reg = '0;
    logic [15:0] wr_data = '0;
    logic        x_req = 1'b0;
    logic [1:0]  x_reg = '0;
    logic [1:0]  x_op = '0;
    logic [15:0] x_addr;
    logic        y_req = 1'b0;
    logic [1:0]  y_reg = '0;
    logic [1:0]  y_op = '0;
    logic [15:0] y_addr;

    int total = 0;
    int bad = 0;

    logic [15:0] m_ptr  [8];
    logic [15:0] m_step [8];
    logic [15:0] m_mode [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    agu_top u_agu_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_reg(wr_reg), .wr_data(wr_data),
        .x_req(x_req), .x_reg(x_reg), .x_op(x_op), .x_addr(x_addr),
        .y_req(y_req), .y_reg(y_reg), .y_op(y_op), .y_addr(y_addr)
    );

    function automatic logic [15:0] rev16(input logic [15:0] v);
        logic [15:0] o;
        for (int i = 0; i < 16; i++) o[i] = v[15-i];
        return o;
    endfunction

    // expected next pointer from R4 through R8
    function automatic logic [15:0] exp_next(input logic [15:0] p, input logic [15:0] s,
                                             input logic [15:0] m, input logic [1:0] op);
        int d, off, k;
        logic [15:0] msk;
        if (op == 2'd0) return p;
        d = (op == 2'd1) ? 1 : (op == 2'd2) ? -1 : int'($signed(s));
        if (m == 16'hFFFF) return p + 16'(d);
        if (m == 16'h0000) begin
            if (op == 2'd1) return rev16(rev16(p) + 16'h8000);
            if (op == 2'd2) return rev16(rev16(p) - 16'h8000);
            return rev16(rev16(p) + rev16(s));
        end
        msk = 16'h0;
        for (int b = 0; b < 16; b++) if (m >= (16'(1) << b)) msk[b] = 1'b1;
        k = int'(m);
        off = int'(p & msk) + d;
        if (d >= 0 && off > k) off = off - (k + 1);
        else if (off < 0) off = off + (k + 1);
        return (p & ~msk) | (16'(off) & msk);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input string tag, input bit we, input logic [1:0] wk, input logic [2:0] wr,
                       input logic [15:0] wd, input bit xq, input logic [1:0] xr, input logic [1:0] xo,
                       input bit yq, input logic [1:0] yr, input logic [1:0] yo);
        logic [15:0] nx, ny;
        int xi, yi;
        @(negedge clk);
        wr_en = we; wr_kind = wk; wr_reg = wr; wr_data = wd;
        x_req = xq; x_reg = xr; x_op = xo;
        y_req = yq; y_reg = yr; y_op = yo;
        xi = int'(xr);
        yi = 4 + int'(yr);
        #1;
        check(tag, x_addr, m_ptr[xi]);
        check(tag, y_addr, m_ptr[yi]);
        @(posedge clk);
        nx = xq ? exp_next(m_ptr[xi], m_step[xi], m_mode[xi], xo) : m_ptr[xi];
        ny = yq ? exp_next(m_ptr[yi], m_step[yi], m_mode[yi], yo) : m_ptr[yi];
        m_ptr[xi] = nx;
        m_ptr[yi] = ny;
        if (we) begin
            case (wk)
                2'd0: m_ptr[wr] = wd;
                2'd1: m_step[wr] = wd;
                2'd2: m_mode[wr] = wd;
                default: ;
            endcase
        end
    endtask

    task automatic wr(input string tag, input logic [1:0] wk, input logic [2:0] r, input logic [15:0] d);
        cyc(tag, 1'b1, wk, r, d, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 2'd0);
    endtask

    task automatic xop(input string tag, input logic [1:0] r, input logic [1:0] o);
        cyc(tag, 1'b0, 2'd0, 3'd0, 16'h0, 1'b1, r, o, 1'b0, 2'd0, 2'd0);
    endtask

    task automatic yop(input string tag, input logic [1:0] r, input logic [1:0] o);
        cyc(tag, 1'b0, 2'd0, 3'd0, 16'h0, 1'b0, 2'd0, 2'd0, 1'b1, r, o);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < 8; i++) begin
            m_ptr[i] = 16'h0; m_step[i] = 16'h0; m_mode[i] = 16'hFFFF;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values, linear default mode
        for (int r = 0; r < 4; r++)
            cyc("R1", 1'b0, 2'd0, 3'd0, 16'h0, 1'b0, 2'(r), 2'd0, 1'b0, 2'(r), 2'd0);
        xop("R1", 2'd0, 2'd1);
        yop("R1", 2'd3, 2'd3);
        xop("R1", 2'd0, 2'd0);

        // R2: writes of each kind, visible next cycle; kind 3 stores nothing
        wr("R2", 2'd0, 3'd2, 16'h1234);
        xop("R2", 2'd2, 2'd0);
        wr("R2", 2'd0, 3'd5, 16'hBEEF);
        yop("R2", 2'd1, 2'd0);
        wr("R2", 2'd3, 3'd5, 16'h5555);
        yop("R2", 2'd1, 2'd0);

        // R3/R4: same-cycle address, then post-modify; signed step
        xop("R3", 2'd2, 2'd1);
        xop("R3", 2'd2, 2'd2);
        wr("R4", 2'd1, 3'd2, 16'hFFFD);
        xop("R4", 2'd2, 2'd3);
        xop("R4", 2'd2, 2'd0);
        cyc("R4", 1'b0, 2'd0, 3'd0, 16'h0, 1'b0, 2'd2, 2'd1, 1'b0, 2'd0, 2'd0);
        xop("R4", 2'd2, 2'd0);

        // R5: linear wrap at both ends
        wr("R5", 2'd0, 3'd0, 16'hFFFF);
        xop("R5", 2'd0, 2'd1);
        xop("R5", 2'd0, 2'd2);
        xop("R5", 2'd0, 2'd0);

        // R6/R7: buffer of size 5 at base 0x40
        wr("R6", 2'd2, 3'd1, 16'd4);
        wr("R6", 2'd0, 3'd1, 16'h0043);
        xop("R6", 2'd1, 2'd1);
        xop("R6", 2'd1, 2'd1);
        xop("R7", 2'd1, 2'd2);
        xop("R7", 2'd1, 2'd1);
        wr("R6", 2'd1, 3'd1, 16'd3);
        xop("R6", 2'd1, 2'd3);
        xop("R6", 2'd1, 2'd3);
        wr("R7", 2'd1, 3'd1, 16'hFFFE);
        xop("R7", 2'd1, 2'd3);
        xop("R7", 2'd1, 2'd3);
        xop("R7", 2'd1, 2'd0);

        // R8: reverse-carry 16-point sweep on Y pointer 4
        wr("R8", 2'd2, 3'd4, 16'h0000);
        wr("R8", 2'd1, 3'd4, 16'd8);
        wr("R8", 2'd0, 3'd4, 16'h0000);
        for (int i = 0; i < 17; i++) yop("R8", 2'd0, 2'd3);
        yop("R8", 2'd0, 2'd1);
        yop("R8", 2'd0, 2'd2);
        yop("R8", 2'd0, 2'd2);
        yop("R8", 2'd0, 2'd0);

        // R10: write collides with an update of the same pointer
        cyc("R10", 1'b1, 2'd0, 3'd3, 16'h0100, 1'b1, 2'd3, 2'd1, 1'b0, 2'd0, 2'd0);
        xop("R10", 2'd3, 2'd0);

        // R11: Y write while X held, X write while Y held
        cyc("R11", 1'b1, 2'd0, 3'd6, 16'h7777, 1'b0, 2'd1, 2'd0, 1'b1, 2'd2, 2'd0);
        cyc("R11", 1'b1, 2'd0, 3'd1, 16'h2222, 1'b0, 2'd1, 2'd0, 1'b1, 2'd2, 2'd0);
        cyc("R11", 1'b0, 2'd0, 3'd0, 16'h0, 1'b0, 2'd1, 2'd0, 1'b1, 2'd2, 2'd0);

        // R9: random concurrent traffic on both banks
        for (int n = 0; n < 3000; n++) begin
            bit we;
            logic [1:0] wk;
            logic [15:0] wd;
            we = ($urandom % 6) == 0;
            wk = 2'($urandom);
            case ($urandom % 4)
                0: wd = 16'hFFFF;
                1: wd = 16'h0000;
                2: wd = 16'($urandom % 20);
                default: wd = 16'($urandom);
            endcase
            if (wk == 2'd1 && wd[15]) wd = 16'hFFF0 | 16'($urandom % 16);
            cyc("R9", we, wk, 3'($urandom), wd,
                1'($urandom), 2'($urandom), 2'($urandom),
                1'($urandom), 2'($urandom), 2'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule